// File: doc/BRIEF.md
# Median Predictor and Refinement Candidate Generator

This block prepares the work list for the fine-level motion search of one block. On a start pulse it samples the motion vectors of four spatial neighbours (left, top, top-right, top-left), each qualified by an availability flag, together with a set of seed vectors found by the coarse search. From the neighbours it forms a median motion vector predictor. It then emits one refinement centre per cycle over a valid/ready handshake: the predictor, the left vector, the top vector, then each seed in index order.

Every centre is first clamped into the global search area. A centre that equals one already in the list is dropped, so the SAD engine never searches the same point twice. Alongside each centre the block gives the four corners of its local window. The window reaches one column further to the left than to the right, and the same distance up and down. All bounds are clipped to the global area. The SAD engine consumes the stream and the final `cand_last` marks the end of the list.

Top module: `mvp_refine_cand`

## Requirements
- R1: The predictor `mvp_x`/`mvp_y` is, separately for x and for y, the median of the left vector, the top vector and a third vector. The third vector is the top-right vector when `avail_tr` is 1.
- R2: When `avail_tr` is 0, the top-left vector becomes the third vector. When both `avail_tr` and `avail_tl` are 0, the third vector is (0,0).
- R3: A left or top neighbour whose availability flag is 0 counts as the vector (0,0), both in the median and as a candidate.
- R4: A start pulse while idle updates `mvp_x`/`mvp_y` and raises `cand_valid` on the next clock edge. Candidates come in the order predictor, left, top, then seed 0 to seed NSEED-1. Seed k occupies bits [k*MVW +: MVW] of `seed_x`/`seed_y`.
- R5: Each centre is clamped component-wise into [-GX, GX] × [-GY, GY] (default ±128 × ±64) before it is compared or emitted.
- R6: A centre equal in both components to an earlier clamped centre in the order of R4 is skipped. No centre is emitted twice in one list.
- R7: The window of a centre (cx, cy) is x from cx-8 to cx+7 and y from cy-7 to cy+7. Each bound is clipped to the global range of R5.
- R8: With `cand_ready` low the current candidate and its window hold. Each cycle with `cand_valid` and `cand_ready` both high advances to the next candidate. `cand_last` is high on the final candidate, and after it is accepted `cand_valid` and `busy` are low on the next cycle.
- R9: A start pulse while `busy` is high has no effect on the list being emitted or on `mvp_x`/`mvp_y`.
- R10: After reset `cand_valid` and `busy` are low and `mvp_x`/`mvp_y` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sample neighbours and seeds, begin a new list |
| avail_l | input | 1 | Left neighbour available |
| avail_t | input | 1 | Top neighbour available |
| avail_tr | input | 1 | Top-right neighbour available |
| avail_tl | input | 1 | Top-left neighbour available |
| left_x | input | MVW | Left vector, x (signed) |
| left_y | input | MVW | Left vector, y (signed) |
| top_x | input | MVW | Top vector, x |
| top_y | input | MVW | Top vector, y |
| tr_x | input | MVW | Top-right vector, x |
| tr_y | input | MVW | Top-right vector, y |
| tl_x | input | MVW | Top-left vector, x |
| tl_y | input | MVW | Top-left vector, y |
| seed_x | input | NSEED*MVW | Packed coarse seed x components |
| seed_y | input | NSEED*MVW | Packed coarse seed y components |
| busy | output | 1 | A list is being emitted |
| mvp_x | output | MVW | Median predictor, x |
| mvp_y | output | MVW | Median predictor, y |
| cand_valid | output | 1 | Candidate on the outputs is valid |
| cand_ready | input | 1 | Consumer accepts the candidate |
| cand_last | output | 1 | Final candidate of the list |
| cand_x | output | MVW | Candidate centre, x |
| cand_y | output | MVW | Candidate centre, y |
| win_x_lo | output | MVW | Window left bound |
| win_x_hi | output | MVW | Window right bound |
| win_y_lo | output | MVW | Window top bound |
| win_y_hi | output | MVW | Window bottom bound |

## Verification
The predictor and the first candidate appear one clock edge after the edge that samples `start`. The window bounds follow the displayed centre in the same cycle, and every accepted candidate is replaced at the next edge. The bench drives inputs on the falling edge and reads the outputs on the following falling edge, so each sample lies one rising edge after the stimulus it belongs to. It keeps its own index into an expected list built by bench functions, and advances that index only after an edge at which it held `cand_ready` high. The check that `valid` and `busy` are low falls on the falling edge right after the final accept.

// File: rtl/mvp_refine_cand.sv
module mvp_refine_cand #(
  parameter int MVW   = 10,
  parameter int NSEED = 3,
  parameter int GX    = 128,
  parameter int GY    = 64,
  parameter int WXN   = 8,
  parameter int WXP   = 7,
  parameter int WY    = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    avail_l,
  input  logic                    avail_t,
  input  logic                    avail_tr,
  input  logic                    avail_tl,
  input  logic signed [MVW-1:0]   left_x,
  input  logic signed [MVW-1:0]   left_y,
  input  logic signed [MVW-1:0]   top_x,
  input  logic signed [MVW-1:0]   top_y,
  input  logic signed [MVW-1:0]   tr_x,
  input  logic signed [MVW-1:0]   tr_y,
  input  logic signed [MVW-1:0]   tl_x,
  input  logic signed [MVW-1:0]   tl_y,
  input  logic [NSEED*MVW-1:0]    seed_x,
  input  logic [NSEED*MVW-1:0]    seed_y,
  output logic                    busy,
  output logic signed [MVW-1:0]   mvp_x,
  output logic signed [MVW-1:0]   mvp_y,
  output logic                    cand_valid,
  input  logic                    cand_ready,
  output logic                    cand_last,
  output logic signed [MVW-1:0]   cand_x,
  output logic signed [MVW-1:0]   cand_y,
  output logic signed [MVW-1:0]   win_x_lo,
  output logic signed [MVW-1:0]   win_x_hi,
  output logic signed [MVW-1:0]   win_y_lo,
  output logic signed [MVW-1:0]   win_y_hi
);
  localparam int NC = NSEED + 3;
  localparam int IW = $clog2(NC);
  localparam int WW = MVW + 2;

  typedef logic signed [WW-1:0] wide_t;

  localparam wide_t LGX = wide_t'(GX);
  localparam wide_t LGY = wide_t'(GY);
  localparam wide_t DXN = wide_t'(WXN);
  localparam wide_t DXP = wide_t'(WXP);
  localparam wide_t DY  = wide_t'(WY);

  function automatic wide_t widen(input logic signed [MVW-1:0] v);
    return wide_t'(v);
  endfunction

  function automatic logic signed [MVW-1:0] clampw(input wide_t v, input wide_t lim);
    wide_t r;
    if (v > lim)       r = lim;
    else if (v < -lim) r = -lim;
    else               r = v;
    return r[MVW-1:0];
  endfunction

  function automatic logic signed [MVW-1:0] med3(input logic signed [MVW-1:0] a,
                                                 input logic signed [MVW-1:0] b,
                                                 input logic signed [MVW-1:0] c);
    logic signed [MVW-1:0] lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    if (c < lo)      return lo;
    else if (c > hi) return hi;
    else             return c;
  endfunction

  logic signed [MVW-1:0] lx, ly, tx, ty, ox, oy, px, py;

  assign lx = avail_l ? left_x : '0;
  assign ly = avail_l ? left_y : '0;
  assign tx = avail_t ? top_x  : '0;
  assign ty = avail_t ? top_y  : '0;
  assign ox = avail_tr ? tr_x : (avail_tl ? tl_x : '0);
  assign oy = avail_tr ? tr_y : (avail_tl ? tl_y : '0);
  assign px = med3(lx, tx, ox);
  assign py = med3(ly, ty, oy);

  logic signed [MVW-1:0] rx [NC];
  logic signed [MVW-1:0] ry [NC];
  logic signed [MVW-1:0] nx [NC];
  logic signed [MVW-1:0] ny [NC];
  logic [NC-1:0]         keep_in;

  assign rx[0] = px;
  assign ry[0] = py;
  assign rx[1] = lx;
  assign ry[1] = ly;
  assign rx[2] = tx;
  assign ry[2] = ty;

  genvar g;
  generate
    for (g = 0; g < NSEED; g++) begin : g_seed
      assign rx[3+g] = seed_x[g*MVW +: MVW];
      assign ry[3+g] = seed_y[g*MVW +: MVW];
    end
    for (g = 0; g < NC; g++) begin : g_clamp
      assign nx[g] = clampw(widen(rx[g]), LGX);
      assign ny[g] = clampw(widen(ry[g]), LGY);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      keep_in[i] = 1'b1;
      for (int j = 0; j < i; j++)
        if (nx[j] == nx[i] && ny[j] == ny[i]) keep_in[i] = 1'b0;
    end
  end

  logic signed [MVW-1:0] cx_q [NC];
  logic signed [MVW-1:0] cy_q [NC];
  logic [NC-1:0]         keep_q;
  logic [IW-1:0]         ptr, nxt;
  logic                  found;

  always_comb begin
    nxt   = '0;
    found = 1'b0;
    for (int i = 0; i < NC; i++)
      if (!found && i > int'(ptr) && keep_q[i]) begin
        nxt   = IW'(i);
        found = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ptr    <= '0;
      keep_q <= '0;
      mvp_x  <= '0;
      mvp_y  <= '0;
      for (int i = 0; i < NC; i++) begin
        cx_q[i] <= '0;
        cy_q[i] <= '0;
      end
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        ptr    <= '0;
        keep_q <= keep_in;
        mvp_x  <= px;
        mvp_y  <= py;
        for (int i = 0; i < NC; i++) begin
          cx_q[i] <= nx[i];
          cy_q[i] <= ny[i];
        end
      end
    end else if (cand_ready) begin
      if (!found) busy <= 1'b0;
      else        ptr  <= nxt;
    end
  end

  assign cand_valid = busy;
  assign cand_last  = busy && !found;
  assign cand_x     = cx_q[ptr];
  assign cand_y     = cy_q[ptr];
  assign win_x_lo   = clampw(widen(cand_x) - DXN, LGX);
  assign win_x_hi   = clampw(widen(cand_x) + DXP, LGX);
  assign win_y_lo   = clampw(widen(cand_y) - DY,  LGY);
  assign win_y_hi   = clampw(widen(cand_y) + DY,  LGY);
endmodule

// File: rtl/mvp_refine_cand_chk.sv
module mvp_refine_cand_chk #(
  parameter int MVW = 10,
  parameter int GX  = 128,
  parameter int GY  = 64,
  parameter int WXN = 8,
  parameter int WXP = 7,
  parameter int WY  = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  busy,
  input logic signed [MVW-1:0] mvp_x,
  input logic signed [MVW-1:0] mvp_y,
  input logic                  cand_valid,
  input logic                  cand_ready,
  input logic                  cand_last,
  input logic signed [MVW-1:0] cand_x,
  input logic signed [MVW-1:0] cand_y,
  input logic signed [MVW-1:0] win_x_lo,
  input logic signed [MVW-1:0] win_x_hi,
  input logic signed [MVW-1:0] win_y_lo,
  input logic signed [MVW-1:0] win_y_hi
);
  localparam int WW = MVW + 2;
  typedef logic signed [WW-1:0] wide_t;
  localparam wide_t LGX = wide_t'(GX);
  localparam wide_t LGY = wide_t'(GY);
  localparam wide_t DXN = wide_t'(WXN);
  localparam wide_t DXP = wide_t'(WXP);
  localparam wide_t DY  = wide_t'(WY);

  wide_t dxl, dxh, dyl, dyh;
  assign dxl = wide_t'(cand_x) - wide_t'(win_x_lo);
  assign dxh = wide_t'(win_x_hi) - wide_t'(cand_x);
  assign dyl = wide_t'(cand_y) - wide_t'(win_y_lo);
  assign dyh = wide_t'(win_y_hi) - wide_t'(cand_y);

  AST_START_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> cand_valid); // R4
  AST_CENTRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cand_valid |-> wide_t'(cand_x) <= LGX && wide_t'(cand_x) >= -LGX && wide_t'(cand_y) <= LGY && wide_t'(cand_y) >= -LGY); // R5
  AST_NO_REPEAT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) cand_valid && cand_ready && !cand_last |=> cand_x != $past(cand_x) || cand_y != $past(cand_y)); // R6
  AST_WINDOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n) cand_valid |-> dxl >= 0 && dxl <= DXN && dxh >= 0 && dxh <= DXP && dyl >= 0 && dyl <= DY && dyh >= 0 && dyh <= DY); // R7
  AST_WINDOW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cand_valid |-> wide_t'(win_x_lo) >= -LGX && wide_t'(win_x_hi) <= LGX && wide_t'(win_y_lo) >= -LGY && wide_t'(win_y_hi) <= LGY); // R7
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n) cand_valid && !cand_ready |=> cand_valid && $stable(cand_x) && $stable(cand_y) && $stable(cand_last)); // R8
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) cand_valid && cand_ready && cand_last |=> !cand_valid && !busy); // R8
  AST_PRED_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy && !(cand_ready && cand_last) |=> busy && $stable(mvp_x) && $stable(mvp_y)); // R9
endmodule

bind mvp_refine_cand mvp_refine_cand_chk #(
  .MVW(MVW), .GX(GX), .GY(GY), .WXN(WXN), .WXP(WXP), .WY(WY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .mvp_x(mvp_x), .mvp_y(mvp_y),
  .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_last(cand_last),
  .cand_x(cand_x), .cand_y(cand_y),
  .win_x_lo(win_x_lo), .win_x_hi(win_x_hi),
  .win_y_lo(win_y_lo), .win_y_hi(win_y_hi)
);

// File: tb/tb_mvp_refine_cand.sv
module tb_mvp_refine_cand;
  localparam int MVW = 10;
  localparam int NSEED = 3;
  localparam int NC = NSEED + 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, avail_l, avail_t, avail_tr, avail_tl, cand_ready;
  logic signed [MVW-1:0] left_x, left_y, top_x, top_y, tr_x, tr_y, tl_x, tl_y;
  logic [NSEED*MVW-1:0] seed_x, seed_y;
  logic busy, cand_valid, cand_last;
  logic signed [MVW-1:0] mvp_x, mvp_y, cand_x, cand_y, win_x_lo, win_x_hi, win_y_lo, win_y_hi;

  mvp_refine_cand #(.MVW(MVW), .NSEED(NSEED)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .avail_l(avail_l), .avail_t(avail_t), .avail_tr(avail_tr), .avail_tl(avail_tl),
    .left_x(left_x), .left_y(left_y), .top_x(top_x), .top_y(top_y),
    .tr_x(tr_x), .tr_y(tr_y), .tl_x(tl_x), .tl_y(tl_y),
    .seed_x(seed_x), .seed_y(seed_y),
    .busy(busy), .mvp_x(mvp_x), .mvp_y(mvp_y),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_last(cand_last),
    .cand_x(cand_x), .cand_y(cand_y),
    .win_x_lo(win_x_lo), .win_x_hi(win_x_hi), .win_y_lo(win_y_lo), .win_y_hi(win_y_hi)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  int v_al, v_at, v_atr, v_atl;
  int v_lx, v_ly, v_tx, v_ty, v_rx, v_ry, v_kx, v_ky;
  int v_sx [NSEED];
  int v_sy [NSEED];
  int exp_x [NC];
  int exp_y [NC];
  int exp_n, exp_px, exp_py;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int median(input int a, input int b, input int c);
    int s0, s1, s2, t;
    s0 = a; s1 = b; s2 = c;
    if (s0 > s1) begin t = s0; s0 = s1; s1 = t; end
    if (s1 > s2) begin t = s1; s1 = s2; s2 = t; end
    if (s0 > s1) begin t = s0; s0 = s1; s1 = t; end
    return s1;
  endfunction

  function automatic int lim(input int v, input int m);
    return (v > m) ? m : ((v < -m) ? -m : v);
  endfunction

  task automatic build_expected();
    int lx, ly, tx, ty, ox, oy, cx, cy;
    bit dup;
    int rx [NC];
    int ry [NC];
    lx = v_al ? v_lx : 0;  ly = v_al ? v_ly : 0;
    tx = v_at ? v_tx : 0;  ty = v_at ? v_ty : 0;
    ox = v_atr ? v_rx : (v_atl ? v_kx : 0);
    oy = v_atr ? v_ry : (v_atl ? v_ky : 0);
    exp_px = median(lx, tx, ox);
    exp_py = median(ly, ty, oy);
    rx[0] = exp_px; ry[0] = exp_py;
    rx[1] = lx;     ry[1] = ly;
    rx[2] = tx;     ry[2] = ty;
    for (int k = 0; k < NSEED; k++) begin rx[3+k] = v_sx[k]; ry[3+k] = v_sy[k]; end
    exp_n = 0;
    for (int i = 0; i < NC; i++) begin
      cx = lim(rx[i], 128);
      cy = lim(ry[i], 64);
      dup = 0;
      for (int j = 0; j < exp_n; j++)
        if (exp_x[j] == cx && exp_y[j] == cy) dup = 1;
      if (!dup) begin exp_x[exp_n] = cx; exp_y[exp_n] = cy; exp_n++; end
    end
  endtask

  task automatic apply_inputs();
    avail_l = v_al[0]; avail_t = v_at[0]; avail_tr = v_atr[0]; avail_tl = v_atl[0];
    left_x = MVW'(v_lx); left_y = MVW'(v_ly);
    top_x = MVW'(v_tx);  top_y = MVW'(v_ty);
    tr_x = MVW'(v_rx);   tr_y = MVW'(v_ry);
    tl_x = MVW'(v_kx);   tl_y = MVW'(v_ky);
    for (int k = 0; k < NSEED; k++) begin
      seed_x[k*MVW +: MVW] = MVW'(v_sx[k]);
      seed_y[k*MVW +: MVW] = MVW'(v_sy[k]);
    end
  endtask

  function automatic int rnd_mv(input int m);
    int r;
    r = int'($urandom % 4);
    if (r == 0) return int'($urandom % 3) - 1;
    if (r == 1) return int'($urandom % 601) - 300;
    return int'($urandom % (2*m + 1)) - m;
  endfunction

  task automatic randomize_vals();
    v_al = int'($urandom % 4 != 0); v_at = int'($urandom % 4 != 0);
    v_atr = int'($urandom % 2);     v_atl = int'($urandom % 2);
    v_lx = rnd_mv(128); v_ly = rnd_mv(64);
    v_tx = rnd_mv(128); v_ty = rnd_mv(64);
    v_rx = rnd_mv(128); v_ry = rnd_mv(64);
    v_kx = rnd_mv(128); v_ky = rnd_mv(64);
    for (int k = 0; k < NSEED; k++) begin
      if ($urandom % 3 == 0) begin v_sx[k] = v_lx; v_sy[k] = v_ly; end
      else begin v_sx[k] = rnd_mv(128); v_sy[k] = rnd_mv(64); end
    end
  endtask

  task automatic run_case(input bit restarts, input int ready_pct);
    int k;
    bit r;
    build_expected();
    apply_inputs();
    @(negedge clk);
    start = 1'b1;
    cand_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(mvp_x == MVW'(exp_px), "R1 R2 R3 mvp_x", int'(mvp_x), exp_px);
    chk(mvp_y == MVW'(exp_py), "R1 R2 R3 mvp_y", int'(mvp_y), exp_py);
    k = 0;
    while (k < exp_n) begin
      chk(cand_valid == 1'b1 && busy == 1'b1, "R4 R8 valid during list", int'(cand_valid), 1);
      if (!cand_valid) break;
      chk(cand_x == MVW'(exp_x[k]), "R4 R5 R6 cand_x", int'(cand_x), exp_x[k]);
      chk(cand_y == MVW'(exp_y[k]), "R4 R5 R6 cand_y", int'(cand_y), exp_y[k]);
      chk(win_x_lo == MVW'(lim(exp_x[k] - 8, 128)), "R7 win_x_lo", int'(win_x_lo), lim(exp_x[k] - 8, 128));
      chk(win_x_hi == MVW'(lim(exp_x[k] + 7, 128)), "R7 win_x_hi", int'(win_x_hi), lim(exp_x[k] + 7, 128));
      chk(win_y_lo == MVW'(lim(exp_y[k] - 7, 64)), "R7 win_y_lo", int'(win_y_lo), lim(exp_y[k] - 7, 64));
      chk(win_y_hi == MVW'(lim(exp_y[k] + 7, 64)), "R7 win_y_hi", int'(win_y_hi), lim(exp_y[k] + 7, 64));
      chk(cand_last == (k == exp_n - 1), "R8 cand_last", int'(cand_last), int'(k == exp_n - 1));
      chk(mvp_x == MVW'(exp_px) && mvp_y == MVW'(exp_py), "R9 mvp held", int'(mvp_x), exp_px);
      r = (int'($urandom % 100) < ready_pct);
      cand_ready = r;
      if (restarts && ($urandom % 3 == 0)) begin
        randomize_vals();
        apply_inputs();
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (r) k++;
    end
    cand_ready = 1'b0;
    chk(cand_valid == 1'b0, "R8 valid low after last", int'(cand_valid), 0);
    chk(busy == 1'b0, "R8 busy low after last", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; cand_ready = 1'b0;
    v_al = 0; v_at = 0; v_atr = 0; v_atl = 0;
    v_lx = 0; v_ly = 0; v_tx = 0; v_ty = 0; v_rx = 0; v_ry = 0; v_kx = 0; v_ky = 0;
    for (int k = 0; k < NSEED; k++) begin v_sx[k] = 0; v_sy[k] = 0; end
    apply_inputs();
    repeat (3) @(negedge clk);
    chk(cand_valid == 1'b0, "R10 valid in reset", int'(cand_valid), 0);
    chk(busy == 1'b0, "R10 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mvp_x == '0 && mvp_y == '0, "R10 mvp after reset", int'(mvp_x), 0);
    chk(cand_valid == 1'b0, "R10 valid after reset", int'(cand_valid), 0);

    // R3: nothing available, all seeds zero -> single candidate
    run_case(1'b0, 100);

    // R1: median with top-right present
    v_al = 1; v_at = 1; v_atr = 1; v_atl = 1;
    v_lx = 5; v_ly = -3; v_tx = -2; v_ty = 9; v_rx = 12; v_ry = 1; v_kx = 40; v_ky = 40;
    v_sx[0] = 5; v_sy[0] = -3; v_sx[1] = 30; v_sy[1] = 20; v_sx[2] = 30; v_sy[2] = 20;
    run_case(1'b0, 100);

    // R2: top-right missing, top-left used
    v_atr = 0;
    run_case(1'b0, 50);

    // R2: both top corners missing -> zero as third
    v_atl = 0;
    run_case(1'b0, 50);

    // R5 R7: clamping and window clipping at both extremes
    v_atr = 1; v_atl = 0;
    v_lx = 300; v_ly = -100; v_tx = -128; v_ty = 64; v_rx = 127; v_ry = 60;
    v_sx[0] = 128; v_sy[0] = 64; v_sx[1] = -300; v_sy[1] = -64; v_sx[2] = 122; v_sy[2] = -59;
    run_case(1'b0, 70);

    // R9: restarts while busy
    v_lx = 1; v_ly = 2; v_tx = 3; v_ty = 4; v_rx = 5; v_ry = 6;
    v_sx[0] = 7; v_sy[0] = 8; v_sx[1] = 9; v_sy[1] = 10; v_sx[2] = 11; v_sy[2] = 12;
    run_case(1'b1, 40);

    for (int n = 0; n < 400; n++) begin
      randomize_vals();
      run_case(n % 2 == 1, 30 + int'($urandom % 71));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule